// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture Channels

This block is a general-purpose 32-bit timer/counter. A 32-bit prescaler sits in front of it. The prescaler advances on every clock in timer mode. In counter mode it advances on synchronized edges of one of the capture inputs. The counter advances once each time the prescaler reaches its programmed limit.

Four match channels compare their value against the counter at all times. On a match, each channel can raise a sticky interrupt flag, restart the count from zero, or halt counting, in any combination. Each channel also updates its own output pin as programmed. Channels 0 and 1 additionally produce a timed DMA request pulse.

Two capture channels store the counter value when their input shows the selected edge, and can flag an interrupt when they do. Software uses a word-addressed register port with a combinational read path. The interrupt line is a level that stays high while any flag is set.

Register map (word address: meaning):

| Address | Meaning |
|---|---|
| 0 | control: bit0 run, bit1 hold-clear |
| 1 | mode: bits[1:0] count source, bit2 counter input select |
| 2 | count |
| 3 | prescale limit |
| 4 | prescale count |
| 5 | match actions: 3 bits per channel |
| 6 | output actions: 2 bits per channel |
| 7 | capture setup: 3 bits per channel |
| 8 | flags |
| 9–12 | match values 0–3 |
| 13–14 | captured values 0–1 |
| 15 | output pin levels |

Top module: `match_capture_timer`

## Requirements
- R1: After reset every register reads 0, and `match_o`, `dma_req_o` and `irq_o` are low.
- R2: Timer mode (mode[1:0]=0). With the run bit set, the prescale count increments on every clock. On the clock where the prescale count is at or above the limit (address 3), it returns to 0 and the count advances by one. So the count advances once every limit+1 clocks.
- R3: Counter mode. mode[1:0]=1 counts rising edges, 2 counts falling edges and 3 counts both edges of `cap_i[mode[2]]`. The prescaler applies to those edges exactly as it applies to clocks in R2.
- R4: Match action bit 3i+1 enables reset on match for channel i. When the counter advances while it equals match value i, it goes to 0 instead of counting up. The count therefore cycles 0..value.
- R5: Match action bit 3i+2 enables stop on match for channel i. It clears the run bit on the clock edge where the count becomes equal to match value i, so the count holds at that value. Setting the run bit again resumes counting.
- R6: Match action bit 3i enables the interrupt for channel i. It sets flag bit i on the clock edge where the count becomes equal to match value i. With the bit clear, flag bit i stays 0.
- R7: Output action bits [2i+1:2i] set what `match_o[i]` does on channel i's match: 0 leave unchanged, 1 drive low, 2 drive high, 3 toggle. Writing address 15 loads the output levels directly.
- R8: `dma_req_o[i]` (i=0,1) is high for exactly the cycles that directly follow a match event of channel i. During such a cycle the count equals match value i.
- R9: Capture setup bit 3c enables rising-edge capture, bit 3c+1 falling-edge capture and bit 3c+2 the capture interrupt for channel c. After a two-flop synchronizer, the captured value is the count present just before the third rising clock edge after the input change. A capture with the interrupt enabled sets flag bit 4+c.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq_o` is high exactly when any flag is set.
- R11: While control bit1 is set, the count and the prescale count are held at 0.
- R12: The count, prescale count and captured-value addresses are read-only. Writes to them do not change what they read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| cap_i | input | 2 | Capture / count inputs, asynchronous |
| match_o | output | 4 | Match output pins |
| dma_req_o | output | 2 | DMA request pulses for match channels 0 and 1 |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is an exact cycle coincidence. The pin change, the synchronizer latency and the counter value have to line up so that the captured value, or the cycle of a stop, can be predicted exactly. The stimulus therefore starts every run from a hold-clear. The count is then a known function of the number of clocks since the run bit was written. Input pins change on falling clock edges a fixed number of clocks into the run, so the expected captured values and stop points follow arithmetically. Sweeps cover prescale limits, edge selections, every output action from both starting levels on every channel, and the 0..value wrap for several match values including zero.

// File: rtl/mct_pkg.sv
package mct_pkg;
  typedef enum logic [1:0] {ACT_NONE, ACT_LOW, ACT_HIGH, ACT_TOGGLE} out_act_e;
  typedef enum logic [1:0] {SRC_CLK, SRC_RISE, SRC_FALL, SRC_BOTH} cnt_src_e;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_MODE   = 1;
  localparam int ADR_COUNT  = 2;
  localparam int ADR_PLIM   = 3;
  localparam int ADR_PCNT   = 4;
  localparam int ADR_MACT   = 5;
  localparam int ADR_OACT   = 6;
  localparam int ADR_CSET   = 7;
  localparam int ADR_FLAGS  = 8;
  localparam int ADR_MV_BASE = 9;
endpackage

// File: rtl/mct_sync_edge.sv
module mct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], in_i};
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         evt_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] pc_o,
  output logic         tick_o
);
  logic [W-1:0] pc_q;

  // at-or-above keeps a lowered limit from forcing a full wrap
  assign tick_o = evt_i & (pc_q >= limit_i);
  assign pc_o   = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (clr_i) pc_q <= '0;
    else if (evt_i) pc_q <= tick_o ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/mct_match_ch.sv
module mct_match_ch
  import mct_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] nxt_i,
  input  logic [W-1:0] mval_i,
  input  out_act_e     act_i,
  input  logic         lvl_we_i,
  input  logic         lvl_i,
  output logic         hit_o,
  output logic         at_o,
  output logic         out_o
);
  logic out_q;

  assign at_o  = (cnt_i == mval_i);
  assign hit_o = tick_i & (nxt_i == mval_i);
  assign out_o = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else if (hit_o) begin
      unique case (act_i)
        ACT_LOW:    out_q <= 1'b0;
        ACT_HIGH:   out_q <= 1'b1;
        ACT_TOGGLE: out_q <= ~out_q;
        default:    out_q <= out_q;
      endcase
    end else if (lvl_we_i) out_q <= lvl_i;
  end
endmodule

// File: rtl/match_capture_timer.sv
module match_capture_timer
  import mct_pkg::*;
#(
  parameter int W  = 32,
  parameter int NM = 4,
  parameter int NC = 2,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  reg_rdata_o,
  input  logic [NC-1:0] cap_i,
  output logic [NM-1:0] match_o,
  output logic [1:0]    dma_req_o,
  output logic          irq_o
);
  localparam int CV_BASE = ADR_MV_BASE + NM;
  localparam int ADR_OUT = CV_BASE + NC;
  localparam int SEL_W   = (NC > 1) ? $clog2(NC) : 1;
  localparam int MODE_W  = 2 + SEL_W;
  localparam int NF      = NM + NC;

  logic              en_q, clr_q;
  logic [MODE_W-1:0] mode_q;
  logic [W-1:0]      plim_q, tc_q, tc_nxt, pc_w;
  logic [3*NM-1:0]   mact_q;
  logic [2*NM-1:0]   oact_q;
  logic [3*NC-1:0]   cset_q;
  logic [NF-1:0]     flags_q, flag_set;
  logic [W-1:0]      mval_q [NM];
  logic [W-1:0]      cval_q [NC];
  logic [NM-1:0]     hit_v, at_v, irqen_v, rstm_v, stop_v;
  logic [NC-1:0]     rise_v, fall_v, cap_hit;
  logic [1:0]        dma_q;
  logic              evt_raw, evt, tick;
  logic [SEL_W-1:0]  in_sel;
  cnt_src_e          src;

  function automatic logic wsel(input int a);
    return reg_we_i && (reg_addr_i == AW'(a));
  endfunction

  // control, mode, limits, action fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      clr_q  <= 1'b0;
      mode_q <= '0;
      plim_q <= '0;
      mact_q <= '0;
      oact_q <= '0;
      cset_q <= '0;
    end else begin
      if (wsel(ADR_CTRL)) {clr_q, en_q} <= reg_wdata_i[1:0];
      if (|(hit_v & stop_v)) en_q <= 1'b0;
      if (wsel(ADR_MODE)) mode_q <= reg_wdata_i[MODE_W-1:0];
      if (wsel(ADR_PLIM)) plim_q <= reg_wdata_i;
      if (wsel(ADR_MACT)) mact_q <= reg_wdata_i[3*NM-1:0];
      if (wsel(ADR_OACT)) oact_q <= reg_wdata_i[2*NM-1:0];
      if (wsel(ADR_CSET)) cset_q <= reg_wdata_i[3*NC-1:0];
    end
  end

  // count source
  assign src    = cnt_src_e'(mode_q[1:0]);
  assign in_sel = mode_q[2+:SEL_W];

  always_comb begin
    unique case (src)
      SRC_RISE: evt_raw = rise_v[in_sel];
      SRC_FALL: evt_raw = fall_v[in_sel];
      SRC_BOTH: evt_raw = rise_v[in_sel] | fall_v[in_sel];
      default:  evt_raw = 1'b1;
    endcase
  end

  assign evt = en_q & ~clr_q & evt_raw;

  mct_prescaler #(.W(W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_q),
    .evt_i   (evt),
    .limit_i (plim_q),
    .pc_o    (pc_w),
    .tick_o  (tick)
  );

  // main counter
  assign tc_nxt = (|(rstm_v & at_v)) ? '0 : tc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tc_q <= '0;
    else if (clr_q)  tc_q <= '0;
    else if (tick)   tc_q <= tc_nxt;
  end

  // match channels
  for (genvar i = 0; i < NM; i++) begin : g_match
    assign irqen_v[i] = mact_q[3*i];
    assign rstm_v[i]  = mact_q[3*i+1];
    assign stop_v[i]  = mact_q[3*i+2];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  mval_q[i] <= '0;
      else if (wsel(ADR_MV_BASE+i)) mval_q[i] <= reg_wdata_i;
    end

    mct_match_ch #(.W(W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .cnt_i    (tc_q),
      .nxt_i    (tc_nxt),
      .mval_i   (mval_q[i]),
      .act_i    (out_act_e'(oact_q[2*i+:2])),
      .lvl_we_i (wsel(ADR_OUT)),
      .lvl_i    (reg_wdata_i[i]),
      .hit_o    (hit_v[i]),
      .at_o     (at_v[i]),
      .out_o    (match_o[i])
    );
    assign flag_set[i] = hit_v[i] & irqen_v[i];
  end

  // capture channels
  for (genvar c = 0; c < NC; c++) begin : g_cap
    mct_sync_edge #(.STAGES(2)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (cap_i[c]),
      .rise_o (rise_v[c]),
      .fall_o (fall_v[c])
    );
    assign cap_hit[c] = (rise_v[c] & cset_q[3*c]) | (fall_v[c] & cset_q[3*c+1]);
    assign flag_set[NM+c] = cap_hit[c] & cset_q[3*c+2];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cval_q[c] <= '0;
      else if (cap_hit[c]) cval_q[c] <= tc_q;
    end
  end

  // flags: set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else flags_q <= (flags_q & ~(wsel(ADR_FLAGS) ? reg_wdata_i[NF-1:0] : '0)) | flag_set;
  end

  assign irq_o = |flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dma_q <= '0;
    else         dma_q <= hit_v[1:0];
  end
  assign dma_req_o = dma_q;

  // read path
  always_comb begin
    reg_rdata_o = '0;
    case (int'(reg_addr_i))
      ADR_CTRL:  reg_rdata_o[1:0] = {clr_q, en_q};
      ADR_MODE:  reg_rdata_o[MODE_W-1:0] = mode_q;
      ADR_COUNT: reg_rdata_o = tc_q;
      ADR_PLIM:  reg_rdata_o = plim_q;
      ADR_PCNT:  reg_rdata_o = pc_w;
      ADR_MACT:  reg_rdata_o[3*NM-1:0] = mact_q;
      ADR_OACT:  reg_rdata_o[2*NM-1:0] = oact_q;
      ADR_CSET:  reg_rdata_o[3*NC-1:0] = cset_q;
      ADR_FLAGS: reg_rdata_o[NF-1:0] = flags_q;
      ADR_OUT:   reg_rdata_o[NM-1:0] = match_o;
      default: begin
        for (int i = 0; i < NM; i++)
          if (int'(reg_addr_i) == ADR_MV_BASE + i) reg_rdata_o = mval_q[i];
        for (int c = 0; c < NC; c++)
          if (int'(reg_addr_i) == CV_BASE + c) reg_rdata_o = cval_q[c];
      end
    endcase
  end
endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
  parameter int W  = 32,
  parameter int NM = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  tc,
  input logic [W-1:0]  pc,
  input logic          tick,
  input logic          clr,
  input logic          en,
  input logic [NM-1:0] hit,
  input logic [NM-1:0] stop,
  input logic [1:0]    dma,
  input logic [W-1:0]  mval0,
  input logic          cap_hit0,
  input logic [W-1:0]  cval0
);
  AST_TC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc != $past(tc)) |-> (tc == $past(tc) + 1'b1 || tc == '0)); // R2

  AST_TC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !clr) |=> $stable(tc)); // R2

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (tc == '0 && pc == '0)); // R11

  AST_STOP_CLEARS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hit & stop)) |=> !en); // R5

  AST_DMA_AT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma[0] && !$past(clr) && $stable(mval0)) |-> tc == mval0); // R8

  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_hit0 |=> $stable(cval0)); // R9
endmodule

bind match_capture_timer mct_checker #(.W(W), .NM(NM)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tc       (tc_q),
  .pc       (pc_w),
  .tick     (tick),
  .clr      (clr_q),
  .en       (en_q),
  .hit      (hit_v),
  .stop     (stop_v),
  .dma      (dma_req_o),
  .mval0    (mval_q[0]),
  .cap_hit0 (cap_hit[0]),
  .cval0    (cval_q[0])
);

// File: tb/match_capture_timer_tb.sv
`timescale 1ns/1ps
module match_capture_timer_tb;
  localparam logic [3:0] A_CTRL = 4'd0, A_MODE = 4'd1, A_CNT = 4'd2, A_PLIM = 4'd3,
                         A_PCNT = 4'd4, A_MACT = 4'd5, A_OACT = 4'd6, A_CSET = 4'd7,
                         A_FLAG = 4'd8, A_MV0 = 4'd9, A_CV0 = 4'd13, A_OUT = 4'd15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  cap = '0;
  logic [3:0]  mo;
  logic [1:0]  dma;
  logic        irq;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  match_capture_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cap_i(cap),
    .match_o(mo), .dma_req_o(dma), .irq_o(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hold-clear, load limit, run; returns at the falling edge after the run edge
  task automatic start(input logic [31:0] lim);
    wr(A_CTRL, 32'd2);
    wr(A_PLIM, lim);
    wr(A_CTRL, 32'd1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] v, cprev [2];
    cprev[0] = '0; cprev[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reg%0d", a), v, 32'd0);
    end
    chk("R1 pins", {27'd0, mo, dma, irq}, 32'd0);

    // R2: prescaled timer sweep
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 12; n++) begin
        start(32'(p));
        wait_n(n);
        rd(A_CNT, v);  chk($sformatf("R2 count p=%0d n=%0d", p, n), v, 32'(n / (p + 1)));
        rd(A_PCNT, v); chk($sformatf("R2 pcnt p=%0d n=%0d", p, n), v, 32'(n % (p + 1)));
      end

    // R11: hold-clear keeps count at zero
    wr(A_CTRL, 32'd3);
    wait_n(5);
    rd(A_CNT, v);  chk("R11 count held", v, 32'd0);
    rd(A_PCNT, v); chk("R11 pcnt held", v, 32'd0);

    // R3: counter mode, edge kinds and prescale
    for (int s = 1; s < 4; s++)
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 5; k++) begin
          wr(A_MODE, 32'(s));
          start(32'(p));
          for (int j = 0; j < k; j++) begin
            cap[0] = 1'b1; wait_n(4);
            cap[0] = 1'b0; wait_n(4);
          end
          wait_n(4);
          rd(A_CNT, v);
          chk($sformatf("R3 src=%0d p=%0d k=%0d", s, p, k), v,
              32'(((s == 3) ? 2 * k : k) / (p + 1)));
        end
    wr(A_MODE, 32'd5);  // rising edges of input 1
    start(32'd0);
    for (int j = 0; j < 3; j++) begin
      cap[1] = 1'b1; wait_n(4); cap[1] = 1'b0; wait_n(4);
    end
    for (int j = 0; j < 2; j++) begin
      cap[0] = 1'b1; wait_n(4); cap[0] = 1'b0; wait_n(4);
    end
    rd(A_CNT, v); chk("R3 input select", v, 32'd3);
    wr(A_MODE, 32'd0);

    // R4 + R8: reset on match, DMA pulse
    for (int m = 0; m < 5; m++) begin
      wr(A_MV0, 32'(m));
      wr(A_MACT, 32'd2);
      start(32'd0);
      for (int n = 1; n <= 12; n++) begin
        @(negedge clk);
        rd(A_CNT, v);
        chk($sformatf("R4 m=%0d n=%0d", m, n), v, 32'(n % (m + 1)));
        chk($sformatf("R8 dma0 m=%0d n=%0d", m, n), 32'(dma[0]), 32'((n % (m + 1)) == m));
      end
    end

    // R5: stop on match and resume
    wr(A_MACT, 32'd0);
    wr(A_MV0 + 4'd1, 32'd5);
    wr(A_MACT, 32'd1 << 5);
    start(32'd0);
    wait_n(10);
    rd(A_CNT, v);  chk("R5 held at match", v, 32'd5);
    rd(A_CTRL, v); chk("R5 run cleared", v, 32'd0);
    wr(A_CTRL, 32'd1);
    wait_n(3);
    rd(A_CNT, v);  chk("R5 resumed", v, 32'd8);

    // R6 + R10: interrupt flags
    wr(A_FLAG, 32'h3f);
    wr(A_MV0 + 4'd2, 32'd3);
    wr(A_MV0 + 4'd3, 32'd3);
    wr(A_MACT, 32'd1 << 6);
    start(32'd0);
    wait_n(6);
    rd(A_FLAG, v); chk("R6 only enabled flag", v, 32'd4);
    chk("R10 irq high", 32'(irq), 32'd1);
    wr(A_FLAG, 32'd0);
    rd(A_FLAG, v); chk("R10 zero write keeps", v, 32'd4);
    wr(A_FLAG, 32'd4);
    rd(A_FLAG, v); chk("R10 cleared", v, 32'd0);
    chk("R10 irq low", 32'(irq), 32'd0);

    // R7: output actions, every channel, both starting levels
    for (int ch = 0; ch < 4; ch++)
      for (int act = 0; act < 4; act++)
        for (int init = 0; init < 2; init++) begin
          logic [3:0] base, exp;
          base = (init != 0) ? 4'hf : 4'h0;
          exp = base;
          case (act)
            1: exp[ch] = 1'b0;
            2: exp[ch] = 1'b1;
            3: exp[ch] = ~base[ch];
            default: ;
          endcase
          wr(A_OUT, 32'(base));
          wr(A_OACT, 32'(act) << (2 * ch));
          wr(A_MV0 + 4'(ch), 32'd2);
          wr(A_MACT, 32'd1 << (3 * ch + 2));
          start(32'd0);
          wait_n(5);
          chk($sformatf("R7 ch=%0d act=%0d init=%0d", ch, act, init), 32'(mo), 32'(exp));
          rd(A_OUT, v);
          chk($sformatf("R7 readback ch=%0d act=%0d", ch, act), v, 32'(exp));
        end

    // R9: capture edges and capture flags
    wr(A_MACT, 32'd0);
    wr(A_OACT, 32'd0);
    wr(A_FLAG, 32'h3f);
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 4; s++) begin
        logic [31:0] e;
        wr(A_CSET, 32'(s | 4) << (3 * c));
        start(32'd0);
        wait_n(4);
        cap[c] = 1'b1; wait_n(5);
        cap[c] = 1'b0; wait_n(5);
        e = (s == 0) ? cprev[c] : (s == 1) ? 32'd6 : 32'd11;
        cprev[c] = e;
        rd(A_CV0 + 4'(c), v);
        chk($sformatf("R9 cap c=%0d sel=%0d", c, s), v, e);
        rd(A_FLAG, v);
        chk($sformatf("R9 flag c=%0d sel=%0d", c, s), v & 32'h30, (s != 0) ? 32'd1 << (4 + c) : 32'd0);
        wr(A_FLAG, 32'h3f);
      end

    // R12: read-only addresses
    wr(A_CSET, 32'd0);
    wr(A_CTRL, 32'd0);
    rd(A_CNT, v);
    begin
      logic [31:0] hold;
      hold = v;
      wr(A_CNT, 32'hdead_beef);
      rd(A_CNT, v);  chk("R12 count write ignored", v, hold);
      wr(A_PCNT, 32'h55);
      rd(A_PCNT, v); chk("R12 pcnt write ignored", v, 32'd0);
      wr(A_CV0, 32'h1234);
      rd(A_CV0, v);  chk("R12 capture write ignored", v, cprev[0]);
    end

    done = 1'b1;
    summary();
  end
endmodule